// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block takes an asynchronous DRAM from power-up to normal service and then keeps its contents alive. After reset it holds every strobe inactive through a long settling pause, then drives a burst of back-to-back warm-up cycles of the CAS-before-RAS kind, which use the device's internal row counter. During the pause and the warm-up it owns the memory bus outright. Only when the warm-up ends does it raise `init_done`, and only from then on does it pass host access grants through.

In normal service a free-running interval timer marks one refresh slot per period. Each slot adds one entry to a small pending count. While the count is nonzero the block asks the access controller for the bus. When the bus is granted, it runs one CAS-before-RAS cycle per pending entry and then drops the request. If the pending count is already full when another slot arrives, a sticky error flag is set. If no refresh completes for longer than the retention window, the block returns to warm-up and repeats the full set of warm-up cycles before it grants host access again. All durations are parameters counted in clock cycles.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is asserted and on the cycle after it, `ras_n`, `cas_n` and `we_n` are 1, and `ref_req`, `init_done` and `pend_ovf` are 0.
- R2: After reset is released, `ras_n` and `cas_n` stay 1 for at least PAUSE_CYC cycles. The first CAS fall follows within a few cycles of the pause's end.
- R3: After the pause, exactly INIT_CYCLES strobe cycles run with `init_done` low, without waiting for `ref_gnt`. `init_done` rises after the last of them.
- R4: `host_gnt` is 1 only when `host_req` is 1 and `init_done` is 1.
- R5: Every strobe cycle is CAS-before-RAS. `cas_n` is 0 for at least CSR_CYC cycles before `ras_n` falls, and stays 0 for at least the first CHR_CYC cycles that `ras_n` is low.
- R6: `ras_n` stays low for at least RAS_CYC cycles. Between two RAS pulses it stays high for at least RP_CYC cycles.
- R7: `we_n` is always 1.
- R8: In normal service, one refresh slot is produced every REF_PERIOD_CYC cycles. With `ref_gnt` held at 1, successive RAS falls are REF_PERIOD_CYC cycles apart, within ±2 cycles.
- R9: In normal service, a strobe cycle starts only while `ref_gnt` is 1. `ref_req` stays 1 for as long as `ras_n` is low.
- R10: Up to MAX_PEND slots are queued while the grant is withheld. When the grant returns, the queued slots run back to back. A slot that arrives while the count is full sets `pend_ovf`, which then holds at 1 until reset.
- R11: If no refresh completes for RETAIN_CYC cycles in normal service, `init_done` falls and INIT_CYCLES warm-up cycles run again before `init_done` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host asks for memory access |
| ref_gnt | input | 1 | Access controller hands the bus to the sequencer |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Combined column strobe for both bytes, active low |
| we_n | output | 1 | Write enable, held inactive |
| ref_req | output | 1 | Sequencer asks for the bus |
| host_gnt | output | 1 | Host access allowed |
| init_done | output | 1 | Power-up sequence finished |
| pend_ovf | output | 1 | Sticky flag: a refresh slot arrived while the pending count was full |

## Verification
The hardest states to reach are the full pending count with overflow, and the retention fallback, because both need the grant withheld for many refresh periods. The stimulus keeps the grant high until the strobes are idle, then withholds it for three and a half periods. It checks that RAS stays quiet, that the overflow flag is set, and that the queued cycles run back to back once the grant returns. It then withholds the grant past the retention window, so the block drops `init_done` and a second batch of expected warm-up cycles is matched against the cycles the block produces.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;

    typedef enum logic [1:0] {
        PH_PAUSE,
        PH_WARM,
        PH_RUN
    } seq_phase_e;

    typedef enum logic [1:0] {
        CB_IDLE,
        CB_SETUP,
        CB_ACTIVE,
        CB_PRECH
    } cbr_state_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};

    // Bits needed to hold values 0..n
    function automatic int cnt_w(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rfs_interval_timer.sv
module rfs_interval_timer
    import dram_refresh_pkg::*;
#(
    parameter int PERIOD_CYC = 3900
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);
    localparam int W = cnt_w(PERIOD_CYC);
    localparam logic [W-1:0] LAST = W'(PERIOD_CYC - 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = en && (cnt == LAST);
endmodule

// File: rtl/rfs_pending_queue.sv
module rfs_pending_queue
    import dram_refresh_pkg::*;
#(
    parameter int MAX_PEND = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic tick,
    input  logic take,
    output logic nonzero,
    output logic ovf
);
    localparam int LW = cnt_w(MAX_PEND);
    localparam logic [LW-1:0] FULL = LW'(MAX_PEND);

    logic [LW-1:0] level;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            level <= '0;
        end else begin
            unique case ({tick, take})
                2'b10:   if (level != FULL) level <= level + 1'b1;
                2'b01:   if (level != '0)   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    // Sticky: only reset clears it, a re-init does not.
    always_ff @(posedge clk) begin
        if (rst) begin
            ovf <= 1'b0;
        end else if (!clr && tick && !take && level == FULL) begin
            ovf <= 1'b1;
        end
    end

    assign nonzero = (level != '0);
endmodule

// File: rtl/cbr_strobe_gen.sv
module cbr_strobe_gen
    import dram_refresh_pkg::*;
#(
    parameter int CSR_CYC = 3,
    parameter int CHR_CYC = 2,
    parameter int RAS_CYC = 8,
    parameter int RP_CYC  = 7
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    output logic    busy,
    output logic    done,
    output strobe_t strb
);
    localparam int MAXD = max2(max2(CSR_CYC, CHR_CYC), max2(RAS_CYC, RP_CYC));
    localparam int W = cnt_w(MAXD);
    localparam logic [W-1:0] SETUP_LAST = W'(CSR_CYC - 1);
    localparam logic [W-1:0] ACT_LAST   = W'(RAS_CYC - 1);
    localparam logic [W-1:0] PRE_LAST   = W'(RP_CYC - 1);
    localparam logic [W-1:0] HOLD_LIM   = W'(CHR_CYC);

    cbr_state_e state, nxt;
    logic [W-1:0] cnt, nxt_cnt;
    strobe_t nxt_strb;

    always_comb begin
        nxt     = state;
        nxt_cnt = cnt + 1'b1;
        unique case (state)
            CB_IDLE: begin
                nxt_cnt = '0;
                if (start) nxt = CB_SETUP;
            end
            CB_SETUP:  if (cnt == SETUP_LAST) begin nxt = CB_ACTIVE; nxt_cnt = '0; end
            CB_ACTIVE: if (cnt == ACT_LAST)   begin nxt = CB_PRECH;  nxt_cnt = '0; end
            CB_PRECH:  if (cnt == PRE_LAST)   begin nxt = CB_IDLE;   nxt_cnt = '0; end
            default: begin nxt = CB_IDLE; nxt_cnt = '0; end
        endcase
    end

    // Strobes are registered from the next state so they never glitch.
    always_comb begin
        nxt_strb       = STROBE_IDLE;
        nxt_strb.ras_n = (nxt != CB_ACTIVE);
        nxt_strb.cas_n = !((nxt == CB_SETUP) || (nxt == CB_ACTIVE && nxt_cnt < HOLD_LIM));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= CB_IDLE;
            cnt   <= '0;
            strb  <= STROBE_IDLE;
        end else begin
            state <= nxt;
            cnt   <= nxt_cnt;
            strb  <= nxt_strb;
        end
    end

    assign busy = (state != CB_IDLE);
    assign done = (state == CB_PRECH) && (cnt == PRE_LAST);
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
    import dram_refresh_pkg::*;
#(
    parameter int PAUSE_CYC      = 50000,
    parameter int INIT_CYCLES    = 8,
    parameter int REF_PERIOD_CYC = 3900,
    parameter int RETAIN_CYC     = 2000000,
    parameter int MAX_PEND       = 2,
    parameter int CSR_CYC        = 3,
    parameter int CHR_CYC        = 2,
    parameter int RAS_CYC        = 8,
    parameter int RP_CYC         = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic host_req,
    input  logic ref_gnt,
    output logic ras_n,
    output logic cas_n,
    output logic we_n,
    output logic ref_req,
    output logic host_gnt,
    output logic init_done,
    output logic pend_ovf
);
    localparam int PW = cnt_w(PAUSE_CYC);
    localparam int IW = cnt_w(INIT_CYCLES);
    localparam int RW = cnt_w(RETAIN_CYC);
    localparam logic [PW-1:0] PAUSE_LAST  = PW'(PAUSE_CYC - 1);
    localparam logic [IW-1:0] INIT_LAST   = IW'(INIT_CYCLES - 1);
    localparam logic [RW-1:0] RETAIN_LAST = RW'(RETAIN_CYC - 1);

    seq_phase_e   phase;
    logic [PW-1:0] pause_cnt;
    logic [IW-1:0] warm_cnt;
    logic [RW-1:0] retain_cnt;

    logic    tick, pend_nz, busy, done, start, take, reinit, in_run;
    strobe_t strb;

    assign in_run = (phase == PH_RUN);
    assign reinit = in_run && !busy && (retain_cnt >= RETAIN_LAST);
    assign start  = !busy && !reinit &&
                    ((phase == PH_WARM) || (in_run && pend_nz && ref_gnt));
    assign take   = start && in_run;

    rfs_interval_timer #(.PERIOD_CYC(REF_PERIOD_CYC)) timer_i (
        .clk  (clk),
        .rst  (rst),
        .en   (in_run),
        .tick (tick)
    );

    rfs_pending_queue #(.MAX_PEND(MAX_PEND)) pend_i (
        .clk     (clk),
        .rst     (rst),
        .clr     (!in_run || reinit),
        .tick    (tick),
        .take    (take),
        .nonzero (pend_nz),
        .ovf     (pend_ovf)
    );

    cbr_strobe_gen #(
        .CSR_CYC (CSR_CYC),
        .CHR_CYC (CHR_CYC),
        .RAS_CYC (RAS_CYC),
        .RP_CYC  (RP_CYC)
    ) strobe_i (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .busy  (busy),
        .done  (done),
        .strb  (strb)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_PAUSE;
            pause_cnt  <= '0;
            warm_cnt   <= '0;
            retain_cnt <= '0;
        end else begin
            unique case (phase)
                PH_PAUSE: begin
                    if (pause_cnt == PAUSE_LAST) begin
                        phase    <= PH_WARM;
                        warm_cnt <= '0;
                    end else begin
                        pause_cnt <= pause_cnt + 1'b1;
                    end
                end
                PH_WARM: begin
                    if (done) begin
                        if (warm_cnt == INIT_LAST) begin
                            phase      <= PH_RUN;
                            retain_cnt <= '0;
                        end else begin
                            warm_cnt <= warm_cnt + 1'b1;
                        end
                    end
                end
                PH_RUN: begin
                    if (reinit) begin
                        phase    <= PH_WARM;
                        warm_cnt <= '0;
                    end else if (done) begin
                        retain_cnt <= '0;
                    end else if (retain_cnt != RETAIN_LAST) begin
                        retain_cnt <= retain_cnt + 1'b1;
                    end
                end
                default: phase <= PH_PAUSE;
            endcase
        end
    end

    assign ras_n     = strb.ras_n;
    assign cas_n     = strb.cas_n;
    assign we_n      = strb.we_n;
    assign init_done = in_run;
    assign ref_req   = in_run && (pend_nz || busy);
    assign host_gnt  = host_req && in_run;
endmodule

// File: rtl/dram_refresh_chk.sv
module dram_refresh_chk #(
    parameter int CSR_CYC = 3,
    parameter int CHR_CYC = 2,
    parameter int RAS_CYC = 8,
    parameter int RP_CYC  = 7
) (
    input logic clk,
    input logic rst,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic ref_req,
    input logic ref_gnt,
    input logic host_gnt,
    input logic init_done,
    input logic pend_ovf
);
    logic        ras_d;
    logic [15:0] setup_cnt, low_cnt, high_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            ras_d     <= 1'b1;
            setup_cnt <= '0;
            low_cnt   <= '0;
            high_cnt  <= 16'(RP_CYC);
        end else begin
            ras_d <= ras_n;
            if (cas_n)                                      setup_cnt <= '0;
            else if (ras_n && setup_cnt != '1)              setup_cnt <= setup_cnt + 1'b1;
            if (!ras_n)                                     low_cnt   <= ras_d ? 16'd1 : ((low_cnt != '1) ? low_cnt + 1'b1 : low_cnt);
            if (ras_n)                                      high_cnt  <= !ras_d ? 16'd1 : ((high_cnt != '1) ? high_cnt + 1'b1 : high_cnt);
        end
    end

    // R1
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (ras_n && cas_n && we_n && !ref_req && !init_done && !pend_ovf));
    // R4
    a_r4_host_gated: assert property (@(posedge clk) disable iff (rst)
        host_gnt |-> init_done);
    // R5
    a_r5_cas_setup: assert property (@(posedge clk) disable iff (rst)
        (!ras_n && ras_d) |-> (setup_cnt >= 16'(CSR_CYC)));
    a_r5_cas_hold_first: assert property (@(posedge clk) disable iff (rst)
        (!ras_n && ras_d) |-> !cas_n);
    a_r5_cas_hold_rest: assert property (@(posedge clk) disable iff (rst)
        (!ras_n && !ras_d && low_cnt < 16'(CHR_CYC)) |-> !cas_n);
    // R6
    a_r6_ras_width: assert property (@(posedge clk) disable iff (rst)
        (ras_n && !ras_d) |-> (low_cnt >= 16'(RAS_CYC)));
    a_r6_precharge: assert property (@(posedge clk) disable iff (rst)
        (!ras_n && ras_d) |-> (high_cnt >= 16'(RP_CYC)));
    // R7
    a_r7_we_high: assert property (@(posedge clk) disable iff (rst)
        we_n);
    // R9
    a_r9_bus_held: assert property (@(posedge clk) disable iff (rst)
        (init_done && !ras_n) |-> ref_req);
    // R10
    a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        pend_ovf |=> pend_ovf);
endmodule

bind dram_refresh_seq dram_refresh_chk #(
    .CSR_CYC (CSR_CYC),
    .CHR_CYC (CHR_CYC),
    .RAS_CYC (RAS_CYC),
    .RP_CYC  (RP_CYC)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .ref_req   (ref_req),
    .ref_gnt   (ref_gnt),
    .host_gnt  (host_gnt),
    .init_done (init_done),
    .pend_ovf  (pend_ovf)
);

// File: tb/dram_refresh_seq_tb_top.sv
module dram_refresh_seq_tb_top;
    localparam int PAUSE  = 300;
    localparam int INIT   = 8;
    localparam int PERIOD = 120;
    localparam int RETAIN = 700;
    localparam int CSR    = 3;
    localparam int CHR    = 2;
    localparam int RASW   = 8;
    localparam int RP     = 7;
    localparam int CYCLEN = CSR + RASW + RP + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic host_req = 1'b0;
    logic ref_gnt = 1'b0;
    logic ras_n, cas_n, we_n, ref_req, host_gnt, init_done, pend_ovf;

    int  n_chk = 0;
    int  n_fail = 0;
    int  cyc = 0;
    bit  auto_gnt = 1'b0;
    bit  finished = 1'b0;
    bit  we_low_seen = 1'b0;
    byte sb_q[$];
    int  fall_cnt = 0;
    int  last_fall = 0;

    always #2 clk = ~clk;

    dram_refresh_seq #(
        .PAUSE_CYC(PAUSE), .INIT_CYCLES(INIT), .REF_PERIOD_CYC(PERIOD),
        .RETAIN_CYC(RETAIN), .MAX_PEND(2), .CSR_CYC(CSR), .CHR_CYC(CHR),
        .RAS_CYC(RASW), .RP_CYC(RP)
    ) dut_i (
        .clk(clk), .rst(rst), .host_req(host_req), .ref_gnt(ref_gnt),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ref_req(ref_req),
        .host_gnt(host_gnt), .init_done(init_done), .pend_ovf(pend_ovf)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) ref_gnt <= auto_gnt;

    // Driver: expected warm-up cycles go into the scoreboard
    task automatic push_warm();
        for (int i = 0; i < INIT; i++) sb_q.push_back(8'd87);
    endtask

    task automatic wait_idle_strobes();
        @(negedge clk);
        while (!(ras_n && cas_n)) @(negedge clk);
    endtask

    // Monitor: strobe timing and scoreboard
    int  setup_c = 0, low_c = 0, high_c = RP, hold_c = 0;
    bit  hold_run = 1'b0, pr = 1'b1;
    always @(negedge clk) begin
        if (rst) begin
            pr = 1'b1; setup_c = 0; low_c = 0; high_c = RP; hold_c = 0; hold_run = 1'b0;
        end else begin
            if (!we_n) we_low_seen = 1'b1;
            if (pr && !ras_n) begin
                check(setup_c >= CSR, "R5 cas setup before ras", setup_c, CSR);
                check(high_c >= RP, "R6 ras precharge", high_c, RP);
                if (!init_done) begin
                    if (sb_q.size() == 0) check(1'b0, "R3 unexpected warm-up cycle", 1, 0);
                    else begin
                        byte it;
                        it = sb_q.pop_front();
                        check(it == 8'd87, "R3 warm-up cycle", it, 87);
                    end
                end else begin
                    check(ref_gnt, "R9 start only under grant", ref_gnt, 1);
                end
                fall_cnt++;
                last_fall = cyc;
                low_c = 1;
                hold_c = cas_n ? 0 : 1;
                hold_run = !cas_n;
            end else if (!ras_n) begin
                low_c++;
                if (hold_run && !cas_n) hold_c++; else hold_run = 1'b0;
            end else if (!pr && ras_n) begin
                check(low_c >= RASW, "R6 ras pulse width", low_c, RASW);
                check(hold_c >= CHR, "R5 cas hold after ras", hold_c, CHR);
                high_c = 1;
                setup_c = 0;
            end else begin
                high_c++;
                if (!cas_n) setup_c++; else setup_c = 0;
            end
            pr = ras_n;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        bit quiet;
        int t0, n0;
        host_req = 1'b1;
        push_warm();
        repeat (3) @(negedge clk);
        // R1 reset state
        check(ras_n && cas_n && we_n, "R1 strobes idle in reset", {ras_n, cas_n, we_n}, 7);
        check(!ref_req && !init_done && !pend_ovf, "R1 flags low in reset",
              {ref_req, init_done, pend_ovf}, 0);
        rst = 1'b0;

        // R2 pause, R4 grant withheld
        quiet = 1'b1;
        for (int i = 0; i < PAUSE - 2; i++) begin
            @(negedge clk);
            if (!(ras_n && cas_n) || host_gnt) quiet = 1'b0;
        end
        check(quiet, "R2 strobes idle during pause, R4 no host grant", quiet, 1);
        t0 = 0;
        while (cas_n && t0 < 12) begin @(negedge clk); t0++; end
        check(!cas_n, "R2 first CAS fall after pause", t0, 12);

        // R3 warm-up
        t0 = 0;
        while (!init_done && t0 < INIT * CYCLEN + 40) begin @(negedge clk); t0++; end
        check(init_done, "R3 init_done after warm-up", init_done, 1);
        check(sb_q.size() == 0, "R3 all warm-up cycles seen", sb_q.size(), 0);
        check(host_gnt, "R4 host grant after init", host_gnt, 1);
        host_req = 1'b0;
        @(negedge clk);
        check(!host_gnt, "R4 no grant without request", host_gnt, 0);
        host_req = 1'b1;

        // R8 spacing with grant held
        auto_gnt = 1'b1;
        n0 = fall_cnt;
        while (fall_cnt == n0) @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            t0 = last_fall;
            n0 = fall_cnt;
            while (fall_cnt == n0) @(negedge clk);
            check((last_fall - t0 >= PERIOD - 2) && (last_fall - t0 <= PERIOD + 2),
                  "R8 refresh spacing", last_fall - t0, PERIOD);
        end

        // R10 queueing and overflow, R9 quiet without grant
        wait_idle_strobes();
        check(!pend_ovf, "R10 no overflow while serviced", pend_ovf, 0);
        auto_gnt = 1'b0;
        n0 = fall_cnt;
        repeat (PERIOD * 3 + PERIOD / 2) @(negedge clk);
        check(fall_cnt == n0, "R9 no refresh without grant", fall_cnt - n0, 0);
        check(ref_req, "R9 request raised while pending", ref_req, 1);
        check(pend_ovf, "R10 overflow flagged", pend_ovf, 1);
        auto_gnt = 1'b1;
        repeat (2 * CYCLEN + 8) @(negedge clk);
        check(fall_cnt - n0 >= 2, "R10 queued refreshes run", fall_cnt - n0, 2);
        check(pend_ovf, "R10 overflow sticky", pend_ovf, 1);

        // R11 retention fallback
        wait_idle_strobes();
        push_warm();
        auto_gnt = 1'b0;
        t0 = 0;
        while (init_done && t0 < RETAIN + 60) begin @(negedge clk); t0++; end
        check(!init_done, "R11 init_done drops after retention window", init_done, 0);
        check(!host_gnt, "R4 host grant withheld during re-init", host_gnt, 0);
        t0 = 0;
        while (!init_done && t0 < INIT * CYCLEN + 40) begin @(negedge clk); t0++; end
        check(init_done, "R11 init_done returns", init_done, 1);
        check(sb_q.size() == 0, "R11 warm-up cycles repeated", sb_q.size(), 0);

        // R7, R1/R10 clear on reset
        check(!we_low_seen, "R7 we_n never asserted", we_low_seen, 0);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(!pend_ovf && !init_done, "R10 overflow cleared by reset, R1", {pend_ovf, init_done}, 0);
        finish_run();
    end
endmodule